// File: doc/BRIEF.md
# Strobed bidirectional bus port

This block is one 8-bit peripheral port that carries data both ways over a single shared set of pins. The CPU side writes a byte into an output latch and reads a byte from a separate input latch. The peripheral side pulls a strobe low to capture the pin value into the input latch. It pulls an acknowledge low to turn on the pin drivers, which then present the output latch. A five-signal group carries the handshake and status: output-buffer-full (active low), acknowledge, strobe, input-buffer-full (active high) and one interrupt request that serves both directions.

Two interrupt-enable flip-flops gate the interrupt. One covers the output direction and one covers the input direction. The CPU changes either one with a single-bit set/reset command that carries a 3-bit bit selector. The pins are modelled as separate input, output and output-enable vectors, so a pad wrapper above this block can build the real tristate buffer. All inputs are sampled on the rising clock edge. Strobe and acknowledge act on their falling edges, which the block detects from the value they held in the previous cycle.

Top module: `bidir_strobe_port`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, obf_n is 1, ibf is 0, both interrupt enables are 0 and both latches hold 0. As a result, intr is 0, cpu_rdata is 0 and pad_out is 0.
- R2: cpu_wr high at an edge loads cpu_wdata into the output latch. pad_out shows that value after the edge, and obf_n is 0 after the edge.
- R3: pad_oe is 1 exactly while ack_n is 0, with no clock delay, and pad_out always shows the output latch.
- R4: A falling acknowledge sets obf_n to 1 after the edge. A falling acknowledge is ack_n at 0 in a cycle where it was 1 in the previous cycle. Holding ack_n low has no further effect. A cpu_wr in the same cycle takes precedence, and obf_n stays 0.
- R5: A falling strobe loads pad_in into the input latch and sets ibf to 1 after the edge. A falling strobe is stb_n at 0 in a cycle where it was 1 in the previous cycle. Holding stb_n low does not load the latch again.
- R6: cpu_rd high at an edge clears ibf after the edge. A falling strobe in the same cycle takes precedence, and ibf stays 1.
- R7: cpu_rdata always shows the input latch. It never shows the output latch, and a CPU write leaves it unchanged.
- R8: bsr_en high at an edge with bsr_sel equal to 6 loads bsr_val into the output interrupt enable. With bsr_sel equal to 4, it loads bsr_val into the input interrupt enable. Every other bsr_sel value has no effect.
- R9: intr is 1 when either of two conditions holds, evaluated without clock delay from the current inputs. The output condition is the output enable set, obf_n equal to 1 and ack_n equal to 1. The input condition is the input enable set, ibf equal to 1 and stb_n equal to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Single-cycle write of the output latch |
| cpu_wdata | input | 8 | Byte to send |
| cpu_rd | input | 1 | Single-cycle read of the input latch; clears ibf |
| cpu_rdata | output | 8 | Current input latch |
| bsr_en | input | 1 | Bit set/reset command valid |
| bsr_sel | input | 3 | Bit position addressed by the command |
| bsr_val | input | 1 | Value written to the addressed enable |
| stb_n | input | 1 | Peripheral strobe, falling edge loads the input latch |
| ack_n | input | 1 | Peripheral acknowledge, low enables the drivers |
| pad_in | input | 8 | Pin values seen on the shared bus |
| pad_out | output | 8 | Value driven onto the bus while enabled |
| pad_oe | output | 1 | Driver enable for the bus pins |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full, active high |
| intr | output | 1 | Combined interrupt request, active high |

## Verification
The properties assume that stb_n, ack_n and pad_in are already synchronous to clk and change only between rising edges. They also assume that the edge rules look back only one sampled cycle, so a glitch narrower than a clock period is neither expected nor detected. The stimulus changes every input on the falling clock edge. It holds strobe and acknowledge high during reset, so the previous-cycle value used for edge detection is always defined. It also covers the collision cases: a write together with a falling acknowledge, and a read together with a falling strobe.

// File: rtl/bsp_pkg.sv
// Package: shared constants and the command type for the strobed port.
// Assumes: one 8-bit data path and a 3-bit set/reset bit selector.
package bsp_pkg;
    localparam int DATA_W       = 8;
    localparam int BSR_SEL_W    = 3;
    localparam int INTE_OUT_POS = 6;
    localparam int INTE_IN_POS  = 4;
    localparam int N_INTE       = 2;

    typedef struct packed {
        logic                 en;
        logic [BSR_SEL_W-1:0] sel;
        logic                 val;
    } bsr_cmd_t;
endpackage

// File: rtl/bsp_fall_detect.sv
// Module: detects the falling edge of an active-low control input.
// Assumes: sig_n is synchronous to clk; it reads as idle (1) during reset.
module bsp_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    logic prev_q;

    // Hold the previous sampled level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_n;
    end

    // A falling edge is low now and high in the previous cycle.
    always_comb fall = prev_q & ~sig_n;
endmodule

// File: rtl/bsp_out_chan.sv
// Module: output latch and output-buffer-full flag.
// Assumes: a write in the same cycle as an acknowledge edge wins.
module bsp_out_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         ack_fall,
    output logic         obf_n,
    output logic [W-1:0] latch
);
    // Capture CPU data into the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch <= '0;
        else if (wr_en) latch <= wdata;
    end

    // Drive buffer-full low on a write and release it on an acknowledge edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        obf_n <= 1'b1;
        else if (wr_en)    obf_n <= 1'b0;
        else if (ack_fall) obf_n <= 1'b1;
    end
endmodule

// File: rtl/bsp_in_chan.sv
// Module: input latch and input-buffer-full flag.
// Assumes: a strobe edge in the same cycle as a CPU read wins.
module bsp_in_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_fall,
    input  logic         rd_en,
    input  logic [W-1:0] pad_in,
    output logic         ibf,
    output logic [W-1:0] latch
);
    // Load the pin value into the input latch on a strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch <= '0;
        else if (stb_fall) latch <= pad_in;
    end

    // Set buffer-full on a strobe edge and clear it on a CPU read.
    always_ff @(posedge clk) begin
        if (!rst_n)        ibf <= 1'b0;
        else if (stb_fall) ibf <= 1'b1;
        else if (rd_en)    ibf <= 1'b0;
    end
endmodule

// File: rtl/bsp_irq_ctrl.sv
// Module: the two interrupt-enable flops and the combined request.
// Assumes: enable index 0 serves the output direction and index 1 the input direction.
module bsp_irq_ctrl
    import bsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bsr_cmd_t cmd,
    input  logic     obf_n,
    input  logic     ack_n,
    input  logic     ibf,
    input  logic     stb_n,
    output logic     intr
);
    localparam int SEL_POS [N_INTE] = '{INTE_OUT_POS, INTE_IN_POS};

    logic [N_INTE-1:0] inte_q;

    genvar g;
    generate
        for (g = 0; g < N_INTE; g++) begin : g_inte
            // Update this enable only when the command addresses its bit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    inte_q[g] <= 1'b0;
                else if (cmd.en && (cmd.sel == BSR_SEL_W'(SEL_POS[g])))
                    inte_q[g] <= cmd.val;
            end
        end
    endgenerate

    // Merge both direction requests into the single interrupt line.
    always_comb intr = (inte_q[0] & obf_n & ack_n) | (inte_q[1] & ibf & stb_n);
endmodule

// File: rtl/bidir_strobe_port.sv
// Module: top of the strobed bidirectional port.
// Assumes: all inputs are synchronous to clk; the pad wrapper builds the tristate from pad_oe.
module bidir_strobe_port
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              bsr_en,
    input  logic [BSR_SEL_W-1:0] bsr_sel,
    input  logic              bsr_val,
    input  logic              stb_n,
    input  logic              ack_n,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe,
    output logic              obf_n,
    output logic              ibf,
    output logic              intr
);
    logic     ack_fall;
    logic     stb_fall;
    bsr_cmd_t cmd;

    // Pack the set/reset command fields.
    always_comb cmd = '{en: bsr_en, sel: bsr_sel, val: bsr_val};

    // Acknowledge low is the only driver enable.
    always_comb pad_oe = ~ack_n;

    bsp_fall_detect u_ack_edge (.clk(clk), .rst_n(rst_n), .sig_n(ack_n), .fall(ack_fall));
    bsp_fall_detect u_stb_edge (.clk(clk), .rst_n(rst_n), .sig_n(stb_n), .fall(stb_fall));

    bsp_out_chan #(.W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .wdata(cpu_wdata),
        .ack_fall(ack_fall), .obf_n(obf_n), .latch(pad_out)
    );

    bsp_in_chan #(.W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n), .stb_fall(stb_fall), .rd_en(cpu_rd),
        .pad_in(pad_in), .ibf(ibf), .latch(cpu_rdata)
    );

    bsp_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .obf_n(obf_n), .ack_n(ack_n),
        .ibf(ibf), .stb_n(stb_n), .intr(intr)
    );
endmodule

// File: rtl/bidir_strobe_port_chk.sv
// Module: checker with the port-level properties of the strobed port.
// Assumes: it is attached to every instance of the top through the bind below.
module bidir_strobe_port_chk
    import bsp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              stb_n,
    input logic              ack_n,
    input logic [DATA_W-1:0] pad_in,
    input logic [DATA_W-1:0] pad_out,
    input logic              pad_oe,
    input logic              obf_n,
    input logic              ibf,
    input logic              intr
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (obf_n && !ibf && !intr)); // R1
    AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (!obf_n && pad_out == $past(cpu_wdata))); // R2
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> !pad_oe); // R3
    AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(ack_n) && !cpu_wr) |=> obf_n); // R4
    AST_STB_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb_n && $past(stb_n)) |=> (ibf && cpu_rdata == $past(pad_in))); // R5
    AST_RD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !(!stb_n && $past(stb_n))) |=> !ibf); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!stb_n && $past(stb_n)) |=> $stable(cpu_rdata)); // R7
    AST_INTR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ((obf_n && ack_n) || (ibf && stb_n))); // R9
endmodule

bind bidir_strobe_port bidir_strobe_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .stb_n(stb_n), .ack_n(ack_n),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .obf_n(obf_n),
    .ibf(ibf), .intr(intr)
);

// File: tb/bidir_strobe_port_test.sv
module bidir_strobe_port_test;
    localparam int PERIOD = 10;
    localparam int NV = 21;

    // Vector: wr wdata rd bsr_en sel val stb_n ack_n pin | obf_n ibf intr oe rdata pout
    localparam logic [44:0] VEC [NV] = '{
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b0,1'b0,1'b0,8'h00,8'h00}, // 0 idle R1
        {1'b1,8'hA5,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'hA5}, // 1 write R2
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'hA5}, // 2 hold
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b1,8'h00,8'hA5}, // 3 ack edge R4 R3
        {1'b1,8'h3C,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b1,8'h00,8'h3C}, // 4 ack held, write
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h3C}, // 5 ack release
        {1'b0,8'h00,1'b0,1'b1,3'd6,1'b1,1'b1,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h3C}, // 6 out enable on R8
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b1,8'h00,8'h3C}, // 7 ack edge, ack low masks R9
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b0,1'b1,1'b0,8'h00,8'h3C}, // 8 out request R9
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,8'h5A, 1'b1,1'b1,1'b1,1'b0,8'h5A,8'h3C}, // 9 strobe edge R5
        {1'b0,8'h00,1'b0,1'b1,3'd6,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b1,1'b0,1'b0,8'h5A,8'h3C}, // 10 out enable off R8
        {1'b0,8'h00,1'b0,1'b1,3'd4,1'b1,1'b1,1'b1,8'h00, 1'b1,1'b1,1'b1,1'b0,8'h5A,8'h3C}, // 11 in enable on R8
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,8'h77, 1'b1,1'b1,1'b0,1'b0,8'h77,8'h3C}, // 12 strobe edge, masks R9
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,8'h11, 1'b1,1'b1,1'b0,1'b0,8'h77,8'h3C}, // 13 strobe held R5
        {1'b0,8'h00,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b1,1'b1,1'b0,8'h77,8'h3C}, // 14 in request R9
        {1'b0,8'h00,1'b0,1'b1,3'd5,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b1,1'b1,1'b0,8'h77,8'h3C}, // 15 other bit ignored R8
        {1'b0,8'h00,1'b1,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b1,1'b0,1'b0,1'b0,8'h77,8'h3C}, // 16 read clears R6
        {1'b0,8'h00,1'b1,1'b0,3'd0,1'b0,1'b0,1'b1,8'hC3, 1'b1,1'b1,1'b0,1'b0,8'hC3,8'h3C}, // 17 read vs strobe R6
        {1'b1,8'h99,1'b0,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b1,1'b1,1'b0,8'hC3,8'h99}, // 18 write keeps rdata R7
        {1'b1,8'h42,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b1,1'b1,1'b1,8'hC3,8'h42}, // 19 write vs ack edge R4
        {1'b0,8'h00,1'b1,1'b0,3'd0,1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0,8'hC3,8'h42}  // 20 read
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_wr, cpu_rd, bsr_en, bsr_val, stb_n, ack_n;
    logic [7:0] cpu_wdata, pad_in;
    logic [2:0] bsr_sel;
    logic [7:0] cpu_rdata, pad_out;
    logic       pad_oe, obf_n, ibf, intr;

    int total = 0;
    int bad = 0;

    bidir_strobe_port uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .bsr_en(bsr_en), .bsr_sel(bsr_sel),
        .bsr_val(bsr_val), .stb_n(stb_n), .ack_n(ack_n), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .obf_n(obf_n), .ibf(ibf), .intr(intr)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cpu_wr = 0; cpu_wdata = 0; cpu_rd = 0; bsr_en = 0; bsr_sel = 0;
        bsr_val = 0; stb_n = 1; ack_n = 1; pad_in = 0;
    endtask

    initial begin
        #(PERIOD*5000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        check("R1 obf_n", {7'd0, obf_n}, 8'd1);
        check("R1 ibf", {7'd0, ibf}, 8'd0);
        check("R1 intr", {7'd0, intr}, 8'd0);
        check("R1 rdata", cpu_rdata, 8'h00);
        @(negedge clk) rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cpu_wr, cpu_wdata, cpu_rd, bsr_en, bsr_sel, bsr_val, stb_n, ack_n, pad_in} = VEC[i][44:20];
            @(posedge clk);
            #(PERIOD/4);
            check($sformatf("R4 R2 obf_n v%0d", i), {7'd0, obf_n}, {7'd0, VEC[i][19]});
            check($sformatf("R5 R6 ibf v%0d", i), {7'd0, ibf}, {7'd0, VEC[i][18]});
            check($sformatf("R9 R8 intr v%0d", i), {7'd0, intr}, {7'd0, VEC[i][17]});
            check($sformatf("R3 pad_oe v%0d", i), {7'd0, pad_oe}, {7'd0, VEC[i][16]});
            check($sformatf("R7 rdata v%0d", i), cpu_rdata, VEC[i][15:8]);
            check($sformatf("R2 pad_out v%0d", i), pad_out, VEC[i][7:0]);
        end

        // R3: the driver enable follows acknowledge inside a cycle.
        @(negedge clk) idle_inputs();
        #1 ack_n = 0;
        #1 check("R3 oe on", {7'd0, pad_oe}, 8'd1);
        ack_n = 1;
        #1 check("R3 oe off", {7'd0, pad_oe}, 8'd0);

        // R1: a mid-run reset empties latches, flags and enables.
        @(negedge clk) begin idle_inputs(); bsr_en = 1; bsr_sel = 3'd6; bsr_val = 1; end
        @(negedge clk) begin idle_inputs(); rst_n = 0; end
        @(posedge clk);
        #(PERIOD/4);
        check("R1 rst obf_n", {7'd0, obf_n}, 8'd1);
        check("R1 rst intr", {7'd0, intr}, 8'd0);
        check("R1 rst rdata", cpu_rdata, 8'h00);
        check("R1 rst pad_out", pad_out, 8'h00);
        @(negedge clk) rst_n = 1;
        @(posedge clk);
        #(PERIOD/4);
        check("R1 enable cleared intr", {7'd0, intr}, 8'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule